// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds the return addresses of a small processor's nested calls and interrupt entries. It has eight slots, each thirteen bits wide. A push strobe writes the presented address into the slot at the internal pointer and moves the pointer up. A pop strobe moves the pointer down. The address a return instruction needs is read from the top-of-stack output, which is the slot just below the pointer.

Software cannot read or write the pointer, and no status is raised. A ninth push goes round the ring and replaces the oldest slot. A pop on an empty stack also wraps, and the output then shows whatever that slot holds. The block does not decode instructions and does not own the program counter or the page latch. Pushes and pops never change that latch.

Top module: `ret_addr_stack`

## Requirements
- R1: While reset is asserted, and right after it, every slot reads as zero and the pointer is zero, so `tos_o` is 0.
- R2: A push cycle stores `push_addr_i`, and from the next clock edge `tos_o` equals that address.
- R3: Pops return the stored addresses in reverse order of their pushes (last in, first out).
- R4: The pointer counts modulo 8. The ninth push since the stack was empty overwrites the first stored address, the tenth overwrites the second, and so on, with no flag.
- R5: A pop with the pointer at 0 wraps the pointer to 7, and `tos_o` then shows slot 6, whatever it holds.
- R6: When push and pop are both high in one cycle, the push is performed and the pop is ignored: `tos_o` becomes the pushed address and the pointer advances by one.
- R7: In a cycle with neither strobe, `tos_o` and the pointer keep their values.
- R8: `tos_o` is a combinational read of slot (pointer − 1) mod 8. It reflects a pointer or slot update in the same cycle that update takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| push_i | input | 1 | Push strobe: store `push_addr_i` and advance the pointer |
| pop_i | input | 1 | Pop strobe: step the pointer back |
| push_addr_i | input | 13 | Return address to store on a push |
| tos_o | output | 13 | Address in the slot just below the pointer |

## Verification
The bench drives the stack deeper than eight calls. A design that refused to wrap, or that wrote to the wrong slot, would then return the first-pushed address where the ninth belongs. It also pops the stack empty and past empty. A design with saturating pointer arithmetic would keep showing slot 0 instead of walking round to slot 6 and below. Push and pop are raised together to check that the push wins. A design that let the pop win, or did both, would leave the old top or a misplaced entry on the output. Idle cycles between bursts catch a pointer that drifts without a strobe.

// File: rtl/rstk_pkg.sv
`timescale 1ns/1ps
package rstk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } rstk_op_e;

  // push dominates a coincident pop
  function automatic rstk_op_e rstk_decode(input logic push, input logic pop);
    if (push)     return OP_PUSH;
    else if (pop) return OP_POP;
    else          return OP_IDLE;
  endfunction
endpackage

// File: rtl/rstk_rst_sync.sv
`timescale 1ns/1ps
module rstk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/rstk_ptr.sv
`timescale 1ns/1ps
module rstk_ptr
  import rstk_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rstk_op_e      op,
  output logic [PW-1:0] ptr_q
);
  logic [PW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    unique case (op)
      OP_PUSH: begin ptr_d = ptr_q + 1'b1; ptr_en = 1'b1; end
      OP_POP:  begin ptr_d = ptr_q - 1'b1; ptr_en = 1'b1; end
      default: begin ptr_d = ptr_q;        ptr_en = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/rstk_mem.sv
`timescale 1ns/1ps
module rstk_mem #(
  parameter int AW    = 13,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [AW-1:0] rd_data
);
  logic [AW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == PW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[g] <= '0;
      else if (slot_en) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/ret_addr_stack.sv
`timescale 1ns/1ps
module ret_addr_stack
  import rstk_pkg::*;
#(
  parameter int AW    = 13,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_addr_i,
  output logic [AW-1:0] tos_o
);
  localparam int PW = $clog2(DEPTH);

  logic          rst_q_n;
  rstk_op_e      op;
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] top_idx;
  logic          wr_en;

  rstk_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign op      = rstk_decode(push_i, pop_i);
  assign wr_en   = (op == OP_PUSH);
  assign top_idx = ptr_q - 1'b1;

  rstk_ptr #(.PW(PW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_q_n),
    .op    (op),
    .ptr_q (ptr_q)
  );

  rstk_mem #(.AW(AW), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (wr_en),
    .wr_idx  (ptr_q),
    .wr_data (push_addr_i),
    .rd_idx  (top_idx),
    .rd_data (tos_o)
  );
endmodule

// File: rtl/rstk_chk.sv
`timescale 1ns/1ps
module rstk_chk #(
  parameter int AW = 13,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] push_addr_i,
  input logic [AW-1:0] tos_o,
  input logic [PW-1:0] ptr_q
);
  AST_RESET_ZERO: assert property (@(posedge clk) !arst_n |-> (tos_o == '0) && (ptr_q == '0)); // R1
  AST_PUSH_SHOWS: assert property (@(posedge clk) disable iff (!rst_n) push_i |=> tos_o == $past(push_addr_i)); // R2
  AST_PUSH_WRAP: assert property (@(posedge clk) disable iff (!rst_n) push_i |=> ptr_q == PW'($past(ptr_q) + 1'b1)); // R4
  AST_POP_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (pop_i && !push_i) |=> ptr_q == PW'($past(ptr_q) - 1'b1)); // R5
  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n) (push_i && pop_i) |=> (tos_o == $past(push_addr_i)) && (ptr_q != $past(ptr_q) - 1'b1)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!push_i && !pop_i) |=> $stable(tos_o) && $stable(ptr_q)); // R7
endmodule

bind ret_addr_stack rstk_chk #(.AW(AW), .PW(PW)) u_rstk_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .arst_n      (rst_n),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .push_addr_i (push_addr_i),
  .tos_o       (tos_o),
  .ptr_q       (ptr_q)
);

// File: tb/test_ret_addr_stack.sv
`timescale 1ns/1ps
module test_ret_addr_stack;
  localparam int AW = 13;
  localparam int DEPTH = 8;

  typedef struct {
    logic [AW-1:0] exp;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          push_i;
  logic          pop_i;
  logic [AW-1:0] push_addr_i;
  logic [AW-1:0] tos_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  exp_t          exp_q[$];
  logic [AW-1:0] m_slot [DEPTH];
  int            m_ptr;

  always #4 clk = ~clk;

  ret_addr_stack #(.AW(AW), .DEPTH(DEPTH)) i_ret_addr_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_addr_i (push_addr_i),
    .tos_o       (tos_o)
  );

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: tos_o actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_slot[i] = '0;
    m_ptr = 0;
  endtask

  // driver: one operation per cycle, expected top queued for the monitor
  task automatic do_op(input bit psh, input bit pp, input logic [AW-1:0] d, input string req);
    exp_t e;
    @(negedge clk);
    push_i      = psh;
    pop_i       = pp;
    push_addr_i = d;
    if (psh) begin
      m_slot[m_ptr] = d;
      m_ptr = (m_ptr + 1) % DEPTH;
    end else if (pp) begin
      m_ptr = (m_ptr + DEPTH - 1) % DEPTH;
    end
    e.exp = m_slot[(m_ptr + DEPTH - 1) % DEPTH];
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic settle();
    @(negedge clk);
    push_i = 1'b0;
    pop_i  = 1'b0;
    @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    push_i = 1'b0;
    pop_i  = 1'b0;
    rst_n  = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check(tos_o, '0, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tos_o, '0, "R1 after reset");
  endtask

  // monitor: compares just after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(tos_o, e.exp, e.req);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n       = 1'b0;
    push_i      = 1'b0;
    pop_i       = 1'b0;
    push_addr_i = '0;
    model_reset();
    apply_reset();

    // R2 / R3: short nest, idle gap, unwind
    do_op(1, 0, 13'h0123, "R2 push a");
    do_op(1, 0, 13'h1abc, "R2 push b");
    do_op(1, 0, 13'h0f0f, "R2 push c");
    do_op(0, 0, 13'h1fff, "R7 idle");
    do_op(0, 0, 13'h0000, "R7 idle");
    do_op(0, 1, '0, "R3 pop");
    do_op(0, 1, '0, "R3 pop");
    do_op(0, 1, '0, "R3 pop to empty");

    // R4: ten pushes wrap round the ring, then unwind past empty
    for (int k = 0; k < 10; k++)
      do_op(1, 0, AW'(13'h1000 + 13'(k * 37)), "R4 deep push");
    for (int k = 0; k < 10; k++)
      do_op(0, 1, '0, "R4 pop after overwrite");
    settle();

    // R6: coincident strobes
    do_op(1, 0, 13'h0555, "R2 push");
    do_op(1, 1, 13'h0aaa, "R6 push and pop");
    do_op(0, 0, '0, "R7 idle after collision");
    do_op(0, 1, '0, "R6 pop shows earlier push");
    settle();

    // R5: pop on empty after a fresh reset, then R8 refill
    apply_reset();
    do_op(0, 1, '0, "R5 pop on empty");
    do_op(0, 1, '0, "R5 second wrap pop");
    do_op(1, 0, 13'h1234, "R8 push after wrap");
    do_op(1, 0, 13'h0042, "R8 push");
    do_op(0, 1, '0, "R8 pop");
    settle();
    settle();
    finish_run();
  end
endmodule